// File: doc/BRIEF.md
# Stimulus Channel Write Decoder

This block sits behind a memory-mapped write port that software uses to emit trace stimulus. The address range is split into fixed 256-byte windows, one per stimulus channel. The low byte of each write address tells the block what packet to make and how to treat it. That includes the packet kind (data, flag or trigger), whether delivery is guaranteed or best-effort (invariant), and whether a timestamp is wanted. Each write that is accepted becomes one packet request on a valid/ready output. The request carries the channel, the kind, both attributes, a right-justified payload and a size code.

The block decides whether a write goes through. Writes are discarded without any notice when tracing is switched off globally, when the channel's enable bit is clear, or when the channel number is beyond the implemented count. A write to an enabled channel at an offset that matches no packet kind raises a one-cycle error pulse. The output buffer is a single slot. When that slot cannot take a new packet, a guaranteed write is held off with ready low, while an invariant write is thrown away and a sticky overflow indication is set.

Top module: `stim_write_decoder`

## Requirements
- R1: The channel of a write is its address divided by 256 (address bits above bit 7), and it appears on `pkt_chan_o` of the resulting packet.
- R2: The offset byte (address bits 7:0) must have bits 2:0 equal to zero. Bits 6:4 select the kind: 001 gives data (code 0), 110 gives flag (code 1), and 111 gives trigger (code 2). Any other offset on an enabled, implemented channel produces no packet and pulses `bad_ofs_o` high for exactly one cycle, the cycle after the write is taken.
- R3: Offset bit 7 clear marks the packet guaranteed (`pkt_guar_o`=1) and bit 7 set marks it invariant. Offset bit 3 clear requests a timestamp (`pkt_ts_o`=1) and bit 3 set requests none.
- R4: The size code `wr_size_i` of 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes. Write data is right-justified. The packet payload keeps the low 2^size bytes, and all bytes above them are zero.
- R5: When `wide_en_i` is low, an 8-byte write on a data or trigger channel becomes a 4-byte packet (size code 2) holding the low four bytes.
- R6: A flag packet always has size code 0 and a one-byte payload (the lowest written byte), whatever the write size.
- R7: A write whose channel is NUM_CH or more is taken (ready high) and ignored: no packet and no error pulse.
- R8: While `trace_en_i` is low, or while the channel's bit in `port_en_i` is clear, writes are taken and ignored: no packet and no error pulse.
- R9: A guaranteed write that decodes to a packet drives `wr_ready_o` low for as long as the output slot holds a packet that is not being taken this cycle. When the slot frees, the write is loaded on the same edge.
- R10: An invariant write that finds the slot occupied and not draining is taken and dropped. `overflow_o` goes high on the next cycle and stays high while `trace_en_i` is high. It clears one cycle after `trace_en_i` is low.
- R11: A packet appears on the output the cycle after its write handshake. While `pkt_valid_o` is high and `pkt_ready_i` is low, every output field stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trace_en_i | input | 1 | Global trace enable |
| port_en_i | input | NUM_CH | Per-channel enable mask |
| wide_en_i | input | 1 | Permits 8-byte packets when high |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request accepted |
| wr_addr_i | input | ADDR_W | Write byte address |
| wr_size_i | input | 2 | Write size code (log2 of bytes) |
| wr_data_i | input | 64 | Right-justified write data |
| pkt_valid_o | output | 1 | Packet request valid |
| pkt_ready_i | input | 1 | Packet request taken |
| pkt_chan_o | output | $clog2(NUM_CH) | Channel number |
| pkt_kind_o | output | 2 | 0 data, 1 flag, 2 trigger |
| pkt_guar_o | output | 1 | Guaranteed delivery |
| pkt_ts_o | output | 1 | Timestamp requested |
| pkt_size_o | output | 2 | Payload size code |
| pkt_data_o | output | 64 | Payload, zero above size |
| bad_ofs_o | output | 1 | One-cycle pulse on an undecodable offset |
| overflow_o | output | 1 | Sticky: an invariant packet was dropped |

## Verification
The bench builds the block with NUM_CH = 20 and ADDR_W = 16. Because 20 is not a power of two, the channel field has encodable values (20 to 31) that lie beyond the implemented count, and a 16-bit address also reaches channels up to 255. Both the range check and the padding of the enable mask are therefore exercised. The enable mask leaves channel 5 off, and `wide_en_i` is toggled per write so that both the narrow and the wide size rules are covered. A held-low `pkt_ready_i` sequence drives the stall and drop paths and the overflow clear.

// File: rtl/stim_dec_pkg.sv
package stim_dec_pkg;

  localparam int DATA_W   = 64;
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_IW  = $clog2(LANES);
  localparam int WIN_BITS = 8;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_FLAG = 2'd1,
    KIND_TRIG = 2'd2
  } pkt_kind_e;

  // offset bits 6:4 selector codes
  localparam logic [2:0] SEL_DATA = 3'b001;
  localparam logic [2:0] SEL_FLAG = 3'b110;
  localparam logic [2:0] SEL_TRIG = 3'b111;

  typedef struct packed {
    pkt_kind_e  kind;
    logic       guar;
    logic       ts;
    logic [1:0] size;
  } pkt_attr_t;

endpackage

// File: rtl/stim_addr_decode.sv
module stim_addr_decode
  import stim_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CF_W  = ADDR_W - WIN_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              chan_ok_o,
  output logic              ofs_ok_o,
  output pkt_kind_e         kind_o,
  output logic              guar_o,
  output logic              ts_o
);

  logic [CF_W-1:0]     chan_field;
  logic [WIN_BITS-1:0] ofs;
  logic [2:0]          sel;

  assign chan_field = addr_i[ADDR_W-1:WIN_BITS];
  assign ofs        = addr_i[WIN_BITS-1:0];
  assign sel        = ofs[6:4];

  assign chan_o    = chan_field[CH_W-1:0];
  assign chan_ok_o = ({1'b0, chan_field} < (CF_W+1)'(NUM_CH));

  // a cleared attribute bit requests the attribute
  assign guar_o = ~ofs[7];
  assign ts_o   = ~ofs[3];

  always_comb begin
    kind_o   = KIND_DATA;
    ofs_ok_o = 1'b0;
    if (ofs[2:0] == 3'b000) begin
      unique case (sel)
        SEL_DATA: begin kind_o = KIND_DATA; ofs_ok_o = 1'b1; end
        SEL_FLAG: begin kind_o = KIND_FLAG; ofs_ok_o = 1'b1; end
        SEL_TRIG: begin kind_o = KIND_TRIG; ofs_ok_o = 1'b1; end
        default:  begin kind_o = KIND_DATA; ofs_ok_o = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/stim_size_fmt.sv
module stim_size_fmt
  import stim_dec_pkg::*;
(
  input  logic [1:0]        size_req_i,
  input  logic              wide_en_i,
  input  pkt_kind_e         kind_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        size_o,
  output logic [DATA_W-1:0] payload_o
);

  logic [LANES-1:0] lane_on;

  always_comb begin
    if (kind_i == KIND_FLAG) begin
      size_o = 2'd0;
    end else if ((size_req_i == 2'd3) && !wide_en_i) begin
      size_o = 2'd2;
    end else begin
      size_o = size_req_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // lane g survives when g < 2**size
    assign lane_on[g] = ((LANE_IW'(g) >> size_o) == '0);
    assign payload_o[g*8 +: 8] = lane_on[g] ? wdata_i[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/stim_out_slot.sv
module stim_out_slot
  import stim_dec_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_en_i,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic              pkt_ready_i,
  input  logic [CH_W-1:0]   chan_i,
  input  pkt_attr_t         attr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   chan_o,
  output pkt_attr_t         attr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);

  logic              valid_d, valid_q;
  logic              ovf_d, ovf_q;
  logic [CH_W-1:0]   chan_q;
  pkt_attr_t         attr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    valid_d = valid_q;
    if (load_i) begin
      valid_d = 1'b1;
    end else if (pkt_ready_i) begin
      valid_d = 1'b0;
    end
    ovf_d = trace_en_i ? (ovf_q | drop_i) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      attr_q <= '0;
      data_q <= '0;
    end else if (load_i) begin
      chan_q <= chan_i;
      attr_q <= attr_i;
      data_q <= data_i;
    end
  end

  assign valid_o = valid_q;
  assign chan_o  = chan_q;
  assign attr_o  = attr_q;
  assign data_o  = data_q;
  assign ovf_o   = ovf_q;

endmodule

// File: rtl/stim_write_decoder.sv
module stim_write_decoder
  import stim_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_en_i,
  input  logic [NUM_CH-1:0] port_en_i,
  input  logic              wide_en_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        wr_size_i,
  input  logic [63:0]       wr_data_i,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [CH_W-1:0]   pkt_chan_o,
  output logic [1:0]        pkt_kind_o,
  output logic              pkt_guar_o,
  output logic              pkt_ts_o,
  output logic [1:0]        pkt_size_o,
  output logic [63:0]       pkt_data_o,
  output logic              bad_ofs_o,
  output logic              overflow_o
);

  localparam int CH_SPAN = 1 << CH_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // decode
  logic [CH_W-1:0]    dec_chan;
  logic               dec_chan_ok, dec_ofs_ok, dec_guar, dec_ts;
  pkt_kind_e          dec_kind;
  logic [1:0]         fmt_size;
  logic [DATA_W-1:0]  fmt_data;
  logic [CH_SPAN-1:0] port_pad;

  stim_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i    (wr_addr_i),
    .chan_o    (dec_chan),
    .chan_ok_o (dec_chan_ok),
    .ofs_ok_o  (dec_ofs_ok),
    .kind_o    (dec_kind),
    .guar_o    (dec_guar),
    .ts_o      (dec_ts)
  );

  stim_size_fmt u_fmt (
    .size_req_i (wr_size_i),
    .wide_en_i  (wide_en_i),
    .kind_i     (dec_kind),
    .wdata_i    (wr_data_i),
    .size_o     (fmt_size),
    .payload_o  (fmt_data)
  );

  // acceptance rules
  logic      ch_live, good, bad, slot_busy, load, drop;
  logic      err_d, err_q;
  pkt_attr_t new_attr, out_attr;

  assign port_pad  = CH_SPAN'(port_en_i);
  assign ch_live   = trace_en_i && dec_chan_ok && port_pad[dec_chan];
  assign good      = ch_live && dec_ofs_ok;
  assign bad       = ch_live && !dec_ofs_ok;
  assign slot_busy = pkt_valid_o && !pkt_ready_i;

  assign wr_ready_o = !(good && dec_guar && slot_busy);
  assign load       = wr_valid_i && good && !slot_busy;
  assign drop       = wr_valid_i && good && !dec_guar && slot_busy;
  assign err_d      = wr_valid_i && bad;

  assign new_attr.kind = dec_kind;
  assign new_attr.guar = dec_guar;
  assign new_attr.ts   = dec_ts;
  assign new_attr.size = fmt_size;

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  stim_out_slot #(.CH_W(CH_W)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .trace_en_i  (trace_en_i),
    .load_i      (load),
    .drop_i      (drop),
    .pkt_ready_i (pkt_ready_i),
    .chan_i      (dec_chan),
    .attr_i      (new_attr),
    .data_i      (fmt_data),
    .valid_o     (pkt_valid_o),
    .chan_o      (pkt_chan_o),
    .attr_o      (out_attr),
    .data_o      (pkt_data_o),
    .ovf_o       (overflow_o)
  );

  assign pkt_kind_o = out_attr.kind;
  assign pkt_guar_o = out_attr.guar;
  assign pkt_ts_o   = out_attr.ts;
  assign pkt_size_o = out_attr.size;
  assign bad_ofs_o  = err_q;

endmodule

// File: rtl/stim_write_decoder_chk.sv
module stim_write_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trace_en_i,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic              pkt_valid_o,
  input logic              pkt_ready_i,
  input logic [CH_W-1:0]   pkt_chan_o,
  input logic [1:0]        pkt_kind_o,
  input logic              pkt_guar_o,
  input logic              pkt_ts_o,
  input logic [1:0]        pkt_size_o,
  input logic [63:0]       pkt_data_o,
  input logic              bad_ofs_o,
  input logic              overflow_o
);

  p_stall_only_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o) |-> (pkt_valid_o && !pkt_ready_i));

  p_hold_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o &&
      $stable({pkt_chan_o, pkt_kind_o, pkt_guar_o, pkt_ts_o, pkt_size_o, pkt_data_o})));

  p_flag_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_kind_o == 2'd1) |-> (pkt_size_o == 2'd0 && pkt_data_o[63:8] == 56'd0));

  p_chan_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (int'(pkt_chan_o) < NUM_CH));

  p_err_after_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_ofs_o |-> $past(wr_valid_i && wr_ready_o));

  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && trace_en_i) |=> overflow_o);

  p_off_no_pkt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trace_en_i && !pkt_valid_o) |=> !pkt_valid_o);

  p_payload_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_size_o != 2'd3) |-> ((pkt_data_o >> (7'd8 << pkt_size_o)) == 64'd0));

endmodule

bind stim_write_decoder stim_write_decoder_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trace_en_i  (trace_en_i),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_chan_o  (pkt_chan_o),
  .pkt_kind_o  (pkt_kind_o),
  .pkt_guar_o  (pkt_guar_o),
  .pkt_ts_o    (pkt_ts_o),
  .pkt_size_o  (pkt_size_o),
  .pkt_data_o  (pkt_data_o),
  .bad_ofs_o   (bad_ofs_o),
  .overflow_o  (overflow_o)
);

// File: tb/stim_write_decoder_tb_top.sv
`timescale 1ns/1ps
module stim_write_decoder_tb_top;

  localparam int ADDR_W = 16;
  localparam int NUM_CH = 20;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam logic [63:0] W = 64'h1122_3344_5566_7788;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              trace_en, wide_en, wr_valid, wr_ready, pkt_valid, pkt_ready;
  logic [NUM_CH-1:0] port_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [1:0]        wr_size, pkt_kind, pkt_size;
  logic [63:0]       wr_data, pkt_data;
  logic [CH_W-1:0]   pkt_chan;
  logic              pkt_guar, pkt_ts, bad_ofs, overflow;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  stim_write_decoder #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .trace_en_i (trace_en), .port_en_i (port_en),
    .wide_en_i (wide_en), .wr_valid_i (wr_valid), .wr_ready_o (wr_ready),
    .wr_addr_i (wr_addr), .wr_size_i (wr_size), .wr_data_i (wr_data),
    .pkt_valid_o (pkt_valid), .pkt_ready_i (pkt_ready), .pkt_chan_o (pkt_chan),
    .pkt_kind_o (pkt_kind), .pkt_guar_o (pkt_guar), .pkt_ts_o (pkt_ts),
    .pkt_size_o (pkt_size), .pkt_data_o (pkt_data), .bad_ofs_o (bad_ofs),
    .overflow_o (overflow)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [1:0]  sz;
    logic        wide;
    logic [3:0]  rq;
    logic        ev;
    logic [7:0]  ech;
    logic [1:0]  ek;
    logic        eg;
    logic        ets;
    logic [1:0]  esz;
    logic [63:0] edata;
    logic        eerr;
  } vec_t;

  localparam int NV = 15;
  // rq column: requirement each row targets (R1..R8)
  localparam vec_t VECS [NV] = '{
    '{16'h0398, 2'd2, 1'b1, 4'd1, 1'b1, 8'd3,  2'd0, 1'b0, 1'b0, 2'd2, 64'h5566_7788, 1'b0}, // R1
    '{16'h0710, 2'd3, 1'b1, 4'd3, 1'b1, 8'd7,  2'd0, 1'b1, 1'b1, 2'd3, W,             1'b0}, // R3
    '{16'h00E8, 2'd2, 1'b1, 4'd6, 1'b1, 8'd0,  2'd1, 1'b0, 1'b0, 2'd0, 64'h88,        1'b0}, // R6
    '{16'h13F0, 2'd1, 1'b1, 4'd2, 1'b1, 8'd19, 2'd2, 1'b0, 1'b1, 2'd1, 64'h7788,      1'b0}, // R2
    '{16'h0218, 2'd0, 1'b1, 4'd4, 1'b1, 8'd2,  2'd0, 1'b1, 1'b0, 2'd0, 64'h88,        1'b0}, // R4
    '{16'h0198, 2'd3, 1'b0, 4'd5, 1'b1, 8'd1,  2'd0, 1'b0, 1'b0, 2'd2, 64'h5566_7788, 1'b0}, // R5
    '{16'h0399, 2'd0, 1'b1, 4'd2, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 2'd0, 64'h0,         1'b1}, // R2
    '{16'h0348, 2'd2, 1'b1, 4'd2, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 2'd0, 64'h0,         1'b1}, // R2
    '{16'h1498, 2'd2, 1'b1, 4'd7, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 2'd0, 64'h0,         1'b0}, // R7
    '{16'h1499, 2'd0, 1'b1, 4'd7, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 2'd0, 64'h0,         1'b0}, // R7
    '{16'hC898, 2'd2, 1'b1, 4'd7, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 2'd0, 64'h0,         1'b0}, // R7
    '{16'h0598, 2'd2, 1'b1, 4'd8, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 2'd0, 64'h0,         1'b0}, // R8
    '{16'h0460, 2'd3, 1'b0, 4'd6, 1'b1, 8'd4,  2'd1, 1'b1, 1'b1, 2'd0, 64'h88,        1'b0}, // R6
    '{16'h08F8, 2'd2, 1'b1, 4'd2, 1'b1, 8'd8,  2'd2, 1'b0, 1'b0, 2'd2, 64'h5566_7788, 1'b0}, // R2
    '{16'h0990, 2'd1, 1'b1, 4'd3, 1'b1, 8'd9,  2'd0, 1'b0, 1'b1, 2'd1, 64'h7788,      1'b0}  // R3
  };

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive_wr(input logic [15:0] a, input logic [1:0] s, input logic [63:0] d, input logic wide);
    wr_valid = 1'b1; wr_addr = a; wr_size = s; wr_data = d; wide_en = wide;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; trace_en = 1'b1; wide_en = 1'b1; wr_valid = 1'b0; pkt_ready = 1'b1;
    port_en = 20'hFFFDF; wr_addr = '0; wr_size = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(!pkt_valid && !overflow && !bad_ofs && wr_ready, "R11 reset",
          {pkt_valid, overflow, bad_ofs, wr_ready}, 64'h1);

    // table walk, output always ready
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [63:0] hdr_a, hdr_e;
      tag = $sformatf("R%0d row%0d", VECS[i].rq, i);
      drive_wr(VECS[i].addr, VECS[i].sz, W, VECS[i].wide);
      #1;
      check(wr_ready == 1'b1, tag, wr_ready, 1);
      @(negedge clk);
      wr_valid = 1'b0;
      check(pkt_valid == VECS[i].ev, tag, pkt_valid, VECS[i].ev);
      check(bad_ofs == VECS[i].eerr, tag, bad_ofs, VECS[i].eerr);
      if (VECS[i].ev) begin
        hdr_a = {48'd0, 8'(pkt_chan), pkt_kind, pkt_guar, pkt_ts, pkt_size};
        hdr_e = {48'd0, VECS[i].ech, VECS[i].ek, VECS[i].eg, VECS[i].ets, VECS[i].esz};
        check(hdr_a == hdr_e, tag, hdr_a, hdr_e);
        check(pkt_data == VECS[i].edata, tag, pkt_data, VECS[i].edata);
      end
    end

    // R2: error pulse lasts one cycle
    drive_wr(16'h0399, 2'd0, W, 1'b1);
    @(negedge clk); wr_valid = 1'b0;
    check(bad_ofs, "R2 pulse", bad_ofs, 1);
    @(negedge clk);
    check(!bad_ofs, "R2 pulse end", bad_ofs, 0);

    // R9 / R11: stall on a full slot
    pkt_ready = 1'b0;
    drive_wr(16'h0210, 2'd0, 64'hAA, 1'b1);
    @(negedge clk);
    check(pkt_valid && pkt_data == 64'hAA, "R11 load", pkt_data, 64'hAA);
    drive_wr(16'h0310, 2'd0, 64'hBB, 1'b1);
    #1;
    check(!wr_ready, "R9 stall", wr_ready, 0);
    repeat (3) @(negedge clk);
    check(!wr_ready, "R9 stall held", wr_ready, 0);
    check(pkt_valid && pkt_data == 64'hAA && pkt_chan == 5'd2, "R11 hold", pkt_data, 64'hAA);
    pkt_ready = 1'b1;
    #1;
    check(wr_ready, "R9 release", wr_ready, 1);
    @(negedge clk);
    wr_valid = 1'b0; pkt_ready = 1'b0;
    check(pkt_valid && pkt_data == 64'hBB && pkt_chan == 5'd3, "R9 loaded", pkt_data, 64'hBB);

    // R10: invariant dropped while full
    drive_wr(16'h0498, 2'd0, 64'hCC, 1'b1);
    #1;
    check(wr_ready, "R10 accept", wr_ready, 1);
    @(negedge clk); wr_valid = 1'b0;
    check(overflow, "R10 set", overflow, 1);
    check(pkt_data == 64'hBB, "R10 kept", pkt_data, 64'hBB);
    @(negedge clk);
    check(overflow, "R10 sticky", overflow, 1);

    // R10 clear, R8 global disable
    trace_en = 1'b0; pkt_ready = 1'b1;
    @(negedge clk);
    check(!overflow, "R10 clear", overflow, 0);
    check(!pkt_valid, "R8 drained", pkt_valid, 0);
    drive_wr(16'h0398, 2'd2, W, 1'b1);
    @(negedge clk); wr_valid = 1'b0;
    check(!pkt_valid && !bad_ofs, "R8 disabled", pkt_valid, 0);
    trace_en = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule